// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This block gathers the event signals of an SPI master (mode fault, transmit FIFO above its watermark, transmit FIFO full, receive FIFO holding data, and three spare sources) into a 7-bit sticky status register. It also holds a 7-bit enable mask and drives one level-sensitive interrupt line to the processor. Software reaches the block through a simple register port with separate read and write strobes. It reads pending events and the mask, clears events by writing ones back, and changes the mask only through a pair of write-only set and clear locations.

Most sources are latched on the rising edge of their event input and then stay set until software clears them. The receive-data source is treated as a level: while its input is high the status bit is set again on every cycle, so clearing it has no lasting effect until the FIFO has been drained. The interrupt line comes from a two-state machine. LINE_IDLE moves to LINE_ACTIVE when any status bit is also enabled in the mask (transition ARM). LINE_ACTIVE returns to LINE_IDLE when no enabled bit remains pending (transition RELEASE). Otherwise each state holds (transition STAY). The line is high only in LINE_ACTIVE.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the status register, the mask register and the read data are all zero and the interrupt line is low.
- R2: A read strobe returns the register selected by the address on the next cycle. Address 0x04 returns the status, address 0x10 returns the mask, and addresses 0x08, 0x0C and every unmapped address return zero. The read data holds its value between read strobes.
- R3: Status bits 0, 1 (mode fault), 2 (TX above watermark), 3 (TX full), 5 and 6 are set on the cycle after their event input goes from 0 to 1. They stay set after the input falls until they are cleared.
- R4: Status bit 4 (RX not empty) is set on the cycle after any cycle in which its event input is high. A clear written while that input is high leaves the bit set.
- R5: A write to address 0x04 clears every status bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R6: When a bit's set condition and a clear for that same bit arrive in the same cycle, the bit ends up set.
- R7: A write to 0x08 sets the mask bits written as 1, and a write to 0x0C clears the mask bits written as 1. Zero bits leave the mask unchanged.
- R8: The interrupt line is high on the cycle after a cycle in which status AND mask is non-zero, and low on the cycle after a cycle in which it is zero.
- R9: After writing 0x7F to 0x0C and 0x7F to 0x04 with no event input active, the interrupt line is low and both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data; bits 6:0 are used |
| bus_rdata | output | 32 | Registered read data, bits 31:7 zero |
| evt_i | input | 7 | Event inputs in status-bit order |
| irq_o | output | 1 | Level interrupt request |

## Verification
A write or an event input sampled at one rising edge changes the status or the mask at that same edge. A read strobe sampled at edge k shows its data from edge k onward, and it carries the register values from before that edge's update. The interrupt line follows status and mask one edge later, so it rises two edges after the event input is driven. The bench drives inputs and compares the outputs on the falling edge. A reference model updated on the rising edge holds exactly these latencies, and every cycle the outputs are compared against it. The directed checks wait for the matching number of falling edges before they sample.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    // Register byte offsets; the software map depends on these values.
    localparam int unsigned OFS_STATUS  = 32'h04;
    localparam int unsigned OFS_SET_MSK = 32'h08;
    localparam int unsigned OFS_CLR_MSK = 32'h0C;
    localparam int unsigned OFS_MASK    = 32'h10;

    // Status / mask bit positions shared by all registers.
    localparam int unsigned BIT_MODE_FAULT = 1;
    localparam int unsigned BIT_TX_WMARK   = 2;
    localparam int unsigned BIT_TX_FULL    = 3;
    localparam int unsigned BIT_RX_AVAIL   = 4;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_STATUS,
        RD_MASK
    } rd_src_e;

    typedef enum logic {
        LINE_IDLE,
        LINE_ACTIVE
    } line_state_e;

    typedef struct packed {
        logic clr_sts;
        logic set_msk;
        logic clr_msk;
    } wr_strobe_t;

endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
    import spi_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_strobe_t        strb_o,
    output rd_src_e           rd_src_o
);

    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_SET_MSK = ADDR_W'(OFS_SET_MSK);
    localparam logic [ADDR_W-1:0] A_CLR_MSK = ADDR_W'(OFS_CLR_MSK);
    localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);

    always_comb begin
        strb_o.clr_sts = wr_i && (addr_i == A_STATUS);
        strb_o.set_msk = wr_i && (addr_i == A_SET_MSK);
        strb_o.clr_msk = wr_i && (addr_i == A_CLR_MSK);
    end

    always_comb begin
        rd_src_o = RD_NONE;
        if (rd_i) begin
            if (addr_i == A_STATUS)
                rd_src_o = RD_STATUS;
            else if (addr_i == A_MASK)
                rd_src_o = RD_MASK;
        end
    end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int unsigned          NUM_SRC   = 7,
    parameter logic [NUM_SRC-1:0]   LEVEL_SRC = NUM_SRC'(1 << BIT_RX_AVAIL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_en_i,
    input  logic [NUM_SRC-1:0] clr_bits_i,
    output logic [NUM_SRC-1:0] sts_o
);

    logic [NUM_SRC-1:0] evt_q;
    logic [NUM_SRC-1:0] sts_q;
    logic [NUM_SRC-1:0] set_w;
    logic [NUM_SRC-1:0] clr_w;

    assign clr_w = clr_en_i ? clr_bits_i : '0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (LEVEL_SRC[i]) begin : g_level
            assign set_w[i] = evt_i[i];

            // R4: a high level input keeps the bit set, clear or not
            p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[i] |=> sts_q[i]);
        end else begin : g_edge
            assign set_w[i] = evt_i[i] & ~evt_q[i];

            // R3: a rising input is captured on the next edge
            p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_i[i] && !evt_q[i]) |=> sts_q[i]);
        end

        // R3: a set bit stays set unless a clear targets it
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_q[i] && !(clr_en_i && clr_bits_i[i])) |=> sts_q[i]);

        // R5: a clear with no competing set drops the bit
        p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && clr_bits_i[i] && !set_w[i]) |=> !sts_q[i]);

        // R6: set and clear together leave the bit set
        p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && clr_bits_i[i] && set_w[i]) |=> sts_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
            sts_q <= '0;
        end else begin
            evt_q <= evt_i;
            sts_q <= (sts_q & ~clr_w) | set_w;
        end
    end

    assign sts_o = sts_q;

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en_i,
    input  logic               clr_en_i,
    input  logic [NUM_SRC-1:0] bits_i,
    output logic [NUM_SRC-1:0] msk_o
);

    logic [NUM_SRC-1:0] msk_q;
    logic [NUM_SRC-1:0] set_w;
    logic [NUM_SRC-1:0] clr_w;

    assign set_w = set_en_i ? bits_i : '0;
    assign clr_w = clr_en_i ? bits_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            msk_q <= '0;
        else
            msk_q <= (msk_q | set_w) & ~clr_w;
    end

    assign msk_o = msk_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        // R7: enable port sets, disable port clears
        p_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en_i && bits_i[i]) |=> msk_q[i]);
        p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && bits_i[i]) |=> !msk_q[i]);
    end

    // R7: without a write to either port the mask holds
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> $stable(msk_q));

endmodule

// File: rtl/spi_irq_line.sv
module spi_irq_line
    import spi_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sts_i,
    input  logic [NUM_SRC-1:0] msk_i,
    output logic               irq_o
);

    line_state_e state_q;
    line_state_e state_d;
    logic        pending;

    assign pending = |(sts_i & msk_i);

    // Next state: ARM, RELEASE or STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (pending)  state_d = LINE_ACTIVE;
            LINE_ACTIVE: if (!pending) state_d = LINE_IDLE;
            default:     state_d = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LINE_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LINE_ACTIVE: irq_o = 1'b1;
            default:     irq_o = 1'b0;
        endcase
    end

    // R8: line follows the enabled-pending condition one edge later
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq_o);
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq_o);

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 8,
    parameter int unsigned        DATA_W    = 32,
    parameter int unsigned        NUM_SRC   = 7,
    parameter logic [NUM_SRC-1:0] LEVEL_SRC = NUM_SRC'(1 << BIT_RX_AVAIL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic              irq_o
);

    wr_strobe_t         strb;
    rd_src_e            rd_src;
    logic [NUM_SRC-1:0] sts;
    logic [NUM_SRC-1:0] msk;
    logic [NUM_SRC-1:0] wbits;
    logic [DATA_W-1:0]  rdata_q;
    logic               unused_wdata_hi;

    assign wbits           = bus_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    spi_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_i     (bus_wr),
        .rd_i     (bus_rd),
        .addr_i   (bus_addr),
        .strb_o   (strb),
        .rd_src_o (rd_src)
    );

    spi_irq_status #(.NUM_SRC(NUM_SRC), .LEVEL_SRC(LEVEL_SRC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_en_i   (strb.clr_sts),
        .clr_bits_i (wbits),
        .sts_o      (sts)
    );

    spi_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (strb.set_msk),
        .clr_en_i (strb.clr_msk),
        .bits_i   (wbits),
        .msk_o    (msk)
    );

    spi_irq_line #(.NUM_SRC(NUM_SRC)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .sts_i (sts),
        .msk_i (msk),
        .irq_o (irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            unique case (rd_src)
                RD_STATUS: rdata_q <= DATA_W'(sts);
                RD_MASK:   rdata_q <= DATA_W'(msk);
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

    // R2: write-only and unmapped locations read back as zero
    p_wo_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != ADDR_W'(OFS_STATUS) && bus_addr != ADDR_W'(OFS_MASK))
        |=> (bus_rdata == '0));

    // R2: read data holds between read strobes
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/spi_irq_unit_bench.sv
`timescale 1ns/1ps
module spi_irq_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  evt = '0;
    logic        irq;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    spi_irq_unit u_spi_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_i     (evt),
        .irq_o     (irq)
    );

    // Behavioural reference model, advanced on each rising edge
    logic [6:0]  m_sts, m_msk, m_evq;
    logic [31:0] m_rd;
    logic        m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sts <= '0; m_msk <= '0; m_evq <= '0; m_rd <= '0; m_irq <= 1'b0;
        end else begin
            logic [6:0] setv;
            logic [6:0] clrv;
            setv = (evt & ~m_evq) | (evt & 7'h10);
            clrv = (bus_wr && bus_addr == 8'h04) ? bus_wdata[6:0] : 7'h00;
            m_irq <= (m_sts & m_msk) != 0;
            if (bus_rd) begin
                if (bus_addr == 8'h04)      m_rd <= {25'd0, m_sts};
                else if (bus_addr == 8'h10) m_rd <= {25'd0, m_msk};
                else                        m_rd <= '0;
            end
            m_sts <= (m_sts & ~clrv) | setv;
            if (bus_wr && bus_addr == 8'h08) m_msk <= m_msk | bus_wdata[6:0];
            else if (bus_wr && bus_addr == 8'h0C) m_msk <= m_msk & ~bus_wdata[6:0];
            m_evq <= evt;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle compare against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check({cur_req, " rdata"}, bus_rdata, m_rd);
            check({cur_req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
        end
    end

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata at reset", bus_rdata, 32'h0);
        check("R1 irq at reset", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        rd(8'h04, 32'h0, "R1 status after reset");
        rd(8'h10, 32'h0, "R1 mask after reset");

        cur_req = "R7";
        wr(8'h08, 32'h1E);
        rd(8'h10, 32'h1E, "R7 enable sets");
        wr(8'h0C, 32'h04);
        rd(8'h10, 32'h1A, "R7 disable clears");
        wr(8'h08, 32'h00);
        wr(8'h0C, 32'h00);
        rd(8'h10, 32'h1A, "R7 zero writes ignored");

        cur_req = "R2";
        rd(8'h08, 32'h0, "R2 enable port reads zero");
        rd(8'h0C, 32'h0, "R2 disable port reads zero");
        rd(8'h14, 32'h0, "R2 unmapped reads zero");
        idle(2);
        check("R2 rdata holds", bus_rdata, 32'h0);

        cur_req = "R3";
        evt = 7'h02; @(negedge clk); evt = 7'h00;
        @(negedge clk);
        check("R3 mode fault raises irq", {31'd0, irq}, 32'h1);
        rd(8'h04, 32'h02, "R3 sticky after input drop");

        cur_req = "R5";
        wr(8'h04, 32'h00);
        rd(8'h04, 32'h02, "R5 zero clear ignored");
        wr(8'h04, 32'h02);
        rd(8'h04, 32'h00, "R5 clear by one");
        check("R8 irq released", {31'd0, irq}, 32'h0);

        cur_req = "R4";
        evt = 7'h10; idle(2);
        wr(8'h04, 32'h10);
        rd(8'h04, 32'h10, "R4 level survives clear");
        evt = 7'h00; @(negedge clk);
        wr(8'h04, 32'h10);
        rd(8'h04, 32'h00, "R4 clear after drain");

        cur_req = "R6";
        evt = 7'h08; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h08;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; evt = 7'h00;
        rd(8'h04, 32'h08, "R6 set beats clear");

        cur_req = "R8";
        wr(8'h04, 32'h7F);
        evt = 7'h04; @(negedge clk); evt = 7'h00;
        idle(2);
        check("R8 masked source keeps irq low", {31'd0, irq}, 32'h0);
        wr(8'h08, 32'h04);
        @(negedge clk);
        check("R8 enabling pending source raises irq", {31'd0, irq}, 32'h1);

        cur_req = "R9";
        wr(8'h0C, 32'h7F);
        wr(8'h04, 32'h7F);
        idle(2);
        check("R9 irq low after disable and clear", {31'd0, irq}, 32'h0);
        rd(8'h04, 32'h0, "R9 status zero");
        rd(8'h10, 32'h0, "R9 mask zero");

        cur_req = "R3 R4 R5 R6 R7 R8 mixed";
        begin
            logic [31:0] lf;
            lf = 32'hACE1_1234;
            for (int c = 0; c < 600; c++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                evt = lf[6:0] & lf[13:7];
                bus_wr = lf[14];
                bus_rd = lf[15];
                case (lf[18:16])
                    3'd0, 3'd1: bus_addr = 8'h04;
                    3'd2:       bus_addr = 8'h08;
                    3'd3:       bus_addr = 8'h0C;
                    3'd4, 3'd5: bus_addr = 8'h10;
                    default:    bus_addr = 8'h14;
                endcase
                bus_wdata = {25'd0, lf[25:19]};
                @(negedge clk);
            end
            bus_wr = 1'b0; bus_rd = 1'b0; evt = '0;
            idle(3);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule